// File: doc/BRIEF.md
# VME A24/D16 Slave Register Decoder

This block sits behind the bus transceivers of one multi-channel digitizer module. It watches a 24-bit VME address, the 6-bit address-modifier code, the direction and the data strobe. It turns each matching strobe cycle into a single action. A write can produce a module reset pulse, a sampling-count register write or a per-channel zero-suppression threshold write. A read can pop one channel FIFO, pop the merged FIFO stream for a block transfer, or return the block-transfer cycle count. The block drives DTACK with fixed timing. Any strobe that matches nothing is left unacknowledged, so the bus master sees its own timeout.

The module answers only when address bits 23..20 are zero and bits 19..16 equal the module index strapped on `module_id`. The low 16 bits form the offset. Offsets 0x0000 (reset) and 0x0001 (sampling count) are fixed. Offsets 0x0100 (merged read) and 0x0101 (block-cycle count) are also fixed. Per-channel registers lie in a window of 256-byte pages that starts at page `CH_PAGE`. Channel j uses page `CH_PAGE + j`. Its sub-offset 0x00 is the FIFO read and its sub-offset 0x02 is the threshold write. The inputs are assumed synchronous to `clk`. FIFO heads are assumed to be first-word-fall-through, so the word returned is the head at the moment of the pop.

Top module: `vme_slave_decode`

## Requirements
- R1: An access is decoded only when addr[23:20]==0 and addr[19:16]==module_id. For any other address, DTACK stays high and no strobe fires.
- R2: A write of 0x0100 to offset 0x0000 with modifier 0x3D is acknowledged. It produces exactly one cycle of `mod_reset`.
- R3: A write to offset 0x0000 with modifier 0x3D and any data other than 0x0100 is acknowledged. It produces no strobe of any kind.
- R4: A write to offset 0x0001 with modifier 0x3D produces one cycle of `cnt_we`. In that cycle `wr_data` equals the written data.
- R5: A write with modifier 0x3D to offset ((CH_PAGE+j)<<8)|0x02, for j < NCH, produces one cycle of `thr_we` with only bit j set. In that cycle `wr_data` equals the written data.
- R6: A read with modifier 0x3D of offset ((CH_PAGE+j)<<8)|0x00, for j < NCH, produces one cycle of `fifo_pop` with only bit j set. `rdata` returns bits [16j+15:16j] of `fifo_heads`.
- R7: A read of offset 0x0100 with modifier 0x3B or 0x3F produces one cycle of `merged_pop`. `rdata` returns `merged_data`.
- R8: A read of offset 0x0101 with modifier 0x3B or 0x3F returns `blk_cycles` on `rdata` and pops nothing.
- R9: The following accesses get no DTACK and no strobe: a wrong modifier, a wrong direction, an unmapped offset, or a channel page at or above CH_PAGE+NCH.
- R10: If the strobe is first sampled low at edge k, DTACK goes low after edge k+1. The action strobes fire in that same cycle. DTACK returns high after the first edge that samples the strobe high. One strobe cycle gives at most one action.
- R11: While `rst_n` is low at a clock edge, the block clears `dtack_n` to 1, `rdata` to 0 and every strobe to 0. `rdata` is zero whenever DTACK is high.
- R12: If the strobe is raised before edge k+1 samples it, the access is abandoned. No DTACK and no strobe result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| module_id | input | 4 | Strapped module index compared with addr[19:16] |
| addr | input | 24 | VME address |
| am | input | 6 | Address-modifier code |
| write_en | input | 1 | 1 for a write cycle, 0 for a read cycle |
| ds_n | input | 1 | Data strobe, active low |
| wdata | input | DW | Write data from the bus |
| fifo_heads | input | NCH*DW | Head word of each channel FIFO, channel j in bits [DW*j+DW-1:DW*j] |
| merged_data | input | DW | Head word of the merged FIFO stream |
| blk_cycles | input | DW | Block-transfer cycle count to be read back |
| dtack_n | output | 1 | Data acknowledge, active low |
| rdata | output | DW | Read data, valid while DTACK is low |
| wr_data | output | DW | Data that goes with the write strobes |
| mod_reset | output | 1 | One-cycle module reset pulse |
| cnt_we | output | 1 | One-cycle sampling-count write |
| thr_we | output | NCH | One-cycle per-channel threshold write |
| fifo_pop | output | NCH | One-cycle per-channel FIFO pop |
| merged_pop | output | 1 | One-cycle merged-stream pop |

## Verification
The bench targets the boundaries of the modifier split. A decoder that checks only the offset would acknowledge a 0x3D read of the merged stream, or a 0x3B read of a channel FIFO, and pop data the master never collects. It tries the reset offset with a near-miss data value; a design that ignores the key would reset the module on an ordinary write. It probes channel 0, the last channel and the first page past the window, which catches off-by-one range checks that write a phantom channel or alias back to channel 0. It also samples DTACK one cycle too early and checks for pulses a cycle too late. It abandons a strobe before acknowledge, which exposes a design that acts on the first sample alone and fires an action the master never completed.

// File: rtl/vme_dec_pkg.sv
// Shared constants and the decoded-operation type for the VME slave decoder.
// Assumes A24 addressing and 16-bit data.
package vme_dec_pkg;
    localparam int AW = 24;
    localparam int AMW = 6;

    localparam logic [AMW-1:0] AM_SINGLE = 6'h3D;
    localparam logic [AMW-1:0] AM_BLK_A  = 6'h3B;
    localparam logic [AMW-1:0] AM_BLK_B  = 6'h3F;

    localparam logic [15:0] OFF_RESET  = 16'h0000;
    localparam logic [15:0] OFF_COUNT  = 16'h0001;
    localparam logic [15:0] OFF_MERGED = 16'h0100;
    localparam logic [15:0] OFF_BLKCNT = 16'h0101;
    localparam logic [7:0]  SUB_FIFO   = 8'h00;
    localparam logic [7:0]  SUB_THR    = 8'h02;

    typedef enum logic [2:0] {
        OP_NONE,    // not for this module: no acknowledge
        OP_NOP,     // acknowledged, no action
        OP_RESET,
        OP_COUNT,
        OP_THR,
        OP_FIFO,
        OP_MERGED,
        OP_BLKCNT
    } op_e;
endpackage

// File: rtl/vme_addr_decode.sv
// Combinational address, modifier and direction decode.
// Maps one bus cycle onto an operation code and a channel index.
// Assumes NCH >= 2 and CH_PAGE + NCH <= 256, with CH_PAGE > 1.
module vme_addr_decode
    import vme_dec_pkg::*;
#(
    parameter int NCH     = 32,
    parameter int CH_PAGE = 16,
    parameter int DW      = 16,
    localparam int CH_W   = $clog2(NCH)
) (
    input  logic [3:0]     module_id,
    input  logic [AW-1:0]  addr,
    input  logic [AMW-1:0] am,
    input  logic           write_en,
    input  logic [DW-1:0]  wdata,
    output op_e            op,
    output logic [CH_W-1:0] chan
);
    localparam logic [8:0] PAGE_LO = 9'(CH_PAGE);
    localparam logic [8:0] PAGE_HI = 9'(CH_PAGE + NCH);
    localparam logic [DW-1:0] RESET_KEY = DW'(16'h0100);

    logic        mod_hit;
    logic        am_single;
    logic        am_block;
    logic [15:0] offs;
    logic [7:0]  page;
    logic [7:0]  sub;
    logic        in_window;

    // Split the address and classify the modifier.
    always_comb begin
        offs      = addr[15:0];
        page      = offs[15:8];
        sub       = offs[7:0];
        mod_hit   = (addr[23:20] == 4'h0) && (addr[19:16] == module_id);
        am_single = (am == AM_SINGLE);
        am_block  = (am == AM_BLK_A) || (am == AM_BLK_B);
        in_window = ({1'b0, page} >= PAGE_LO) && ({1'b0, page} < PAGE_HI);
    end

    // Select the operation; anything unmatched stays OP_NONE.
    always_comb begin
        op   = OP_NONE;
        chan = CH_W'(page - PAGE_LO[7:0]);
        if (mod_hit) begin
            if (offs == OFF_RESET && write_en && am_single)
                op = (wdata == RESET_KEY) ? OP_RESET : OP_NOP;
            else if (offs == OFF_COUNT && write_en && am_single)
                op = OP_COUNT;
            else if (offs == OFF_MERGED && !write_en && am_block)
                op = OP_MERGED;
            else if (offs == OFF_BLKCNT && !write_en && am_block)
                op = OP_BLKCNT;
            else if (in_window && am_single) begin
                if (sub == SUB_FIFO && !write_en)
                    op = OP_FIFO;
                else if (sub == SUB_THR && write_en)
                    op = OP_THR;
            end
        end
    end
endmodule

// File: rtl/vme_strobe_fsm.sv
// Data-strobe handshake. A strobe first seen at edge k is decoded there.
// It is acted on and acknowledged at edge k+1 if the strobe is still low.
// The acknowledge is released on the first edge that sees the strobe high.
// Assumes ds_n is synchronous to clk.
module vme_strobe_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic ds_n,
    input  logic hit,
    output logic capture,
    output logic fire,
    output logic clear,
    output logic dtack_n
);
    typedef enum logic [1:0] {S_IDLE, S_LATCH, S_HOLD, S_DROP} st_e;
    st_e state;

    // Control pulses derived from the present state and the strobe.
    always_comb begin
        capture = (state == S_IDLE) && !ds_n;
        fire    = (state == S_LATCH) && !ds_n && hit;
        clear   = (state == S_HOLD) && ds_n;
    end

    // State register and registered acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            dtack_n <= 1'b1;
        end else begin
            case (state)
                S_IDLE:  if (!ds_n) state <= S_LATCH;
                S_LATCH: begin
                    if (ds_n)
                        state <= S_IDLE;
                    else if (hit) begin
                        state   <= S_HOLD;
                        dtack_n <= 1'b0;
                    end else
                        state <= S_DROP;
                end
                S_HOLD, S_DROP: begin
                    if (ds_n) begin
                        state   <= S_IDLE;
                        dtack_n <= 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vme_action_gen.sv
// Turns a latched operation into one-cycle strobes and registered read data.
// Assumes FIFO heads are first-word-fall-through, so the word read is the head
// at the time of the pop.
module vme_action_gen
    import vme_dec_pkg::*;
#(
    parameter int NCH   = 32,
    parameter int DW    = 16,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              clear,
    input  op_e               op,
    input  logic [CH_W-1:0]   chan,
    input  logic [DW-1:0]     wdata,
    input  logic [NCH*DW-1:0] fifo_heads,
    input  logic [DW-1:0]     merged_data,
    input  logic [DW-1:0]     blk_cycles,
    output logic [DW-1:0]     rdata,
    output logic [DW-1:0]     wr_data,
    output logic              mod_reset,
    output logic              cnt_we,
    output logic [NCH-1:0]    thr_we,
    output logic [NCH-1:0]    fifo_pop,
    output logic              merged_pop
);
    logic [NCH-1:0] thr_hit;
    logic [NCH-1:0] pop_hit;

    // Per-channel select lines from the latched channel index.
    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign thr_hit[g] = fire && (op == OP_THR)  && (chan == CH_W'(g));
        assign pop_hit[g] = fire && (op == OP_FIFO) && (chan == CH_W'(g));
    end

    // One-cycle action strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_reset  <= 1'b0;
            cnt_we     <= 1'b0;
            thr_we     <= '0;
            fifo_pop   <= '0;
            merged_pop <= 1'b0;
        end else begin
            mod_reset  <= fire && (op == OP_RESET);
            cnt_we     <= fire && (op == OP_COUNT);
            thr_we     <= thr_hit;
            fifo_pop   <= pop_hit;
            merged_pop <= fire && (op == OP_MERGED);
        end
    end

    // Write data that goes with the write strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_data <= '0;
        else if (fire && (op == OP_COUNT || op == OP_THR))
            wr_data <= wdata;
    end

    // Read data: loaded on acknowledge, cleared on release.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (fire) begin
            case (op)
                OP_FIFO:   rdata <= fifo_heads[chan*DW +: DW];
                OP_MERGED: rdata <= merged_data;
                OP_BLKCNT: rdata <= blk_cycles;
                default:   rdata <= '0;
            endcase
        end else if (clear)
            rdata <= '0;
    end
endmodule

// File: rtl/vme_slave_decode.sv
// VME A24/D16 slave decoder for one digitizer module.
// It latches the decode of each new data strobe and acts one clock later
// if the strobe is still held. It acknowledges only mapped accesses.
// Assumes all bus inputs are synchronous to clk.
module vme_slave_decode
    import vme_dec_pkg::*;
#(
    parameter int NCH     = 32,
    parameter int CH_PAGE = 16,
    parameter int DW      = 16,
    localparam int CH_W   = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        module_id,
    input  logic [AW-1:0]     addr,
    input  logic [AMW-1:0]    am,
    input  logic              write_en,
    input  logic              ds_n,
    input  logic [DW-1:0]     wdata,
    input  logic [NCH*DW-1:0] fifo_heads,
    input  logic [DW-1:0]     merged_data,
    input  logic [DW-1:0]     blk_cycles,
    output logic              dtack_n,
    output logic [DW-1:0]     rdata,
    output logic [DW-1:0]     wr_data,
    output logic              mod_reset,
    output logic              cnt_we,
    output logic [NCH-1:0]    thr_we,
    output logic [NCH-1:0]    fifo_pop,
    output logic              merged_pop
);
    op_e             op_d;
    op_e             op_q;
    logic [CH_W-1:0] chan_d;
    logic [CH_W-1:0] chan_q;
    logic [DW-1:0]   wdata_q;
    logic            capture;
    logic            fire;
    logic            clear;

    vme_addr_decode #(.NCH(NCH), .CH_PAGE(CH_PAGE), .DW(DW)) u_decode (
        .module_id (module_id),
        .addr      (addr),
        .am        (am),
        .write_en  (write_en),
        .wdata     (wdata),
        .op        (op_d),
        .chan      (chan_d)
    );

    // Hold the decode taken on the first strobe sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_NONE;
            chan_q  <= '0;
            wdata_q <= '0;
        end else if (capture) begin
            op_q    <= op_d;
            chan_q  <= chan_d;
            wdata_q <= wdata;
        end
    end

    vme_strobe_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ds_n    (ds_n),
        .hit     (op_q != OP_NONE),
        .capture (capture),
        .fire    (fire),
        .clear   (clear),
        .dtack_n (dtack_n)
    );

    vme_action_gen #(.NCH(NCH), .DW(DW)) u_action (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire        (fire),
        .clear       (clear),
        .op          (op_q),
        .chan        (chan_q),
        .wdata       (wdata_q),
        .fifo_heads  (fifo_heads),
        .merged_data (merged_data),
        .blk_cycles  (blk_cycles),
        .rdata       (rdata),
        .wr_data     (wr_data),
        .mod_reset   (mod_reset),
        .cnt_we      (cnt_we),
        .thr_we      (thr_we),
        .fifo_pop    (fifo_pop),
        .merged_pop  (merged_pop)
    );
endmodule

// Protocol checker for vme_slave_decode, attached by bind below.
module vme_slave_decode_chk #(
    parameter int NCH = 32,
    parameter int DW  = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ds_n,
    input logic           dtack_n,
    input logic [DW-1:0]  rdata,
    input logic           mod_reset,
    input logic           cnt_we,
    input logic [NCH-1:0] thr_we,
    input logic [NCH-1:0] fifo_pop,
    input logic           merged_pop
);
    logic any_pulse;
    assign any_pulse = mod_reset | cnt_we | (|thr_we) | (|fifo_pop) | merged_pop;

    p_reset_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mod_reset |=> !mod_reset);

    p_thr_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(thr_we));

    p_pop_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fifo_pop));

    p_pulse_with_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        any_pulse |-> $fell(dtack_n));

    p_ack_after_two_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dtack_n) |-> ($past(ds_n) == 1'b0 && $past(ds_n, 2) == 1'b0));

    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n && ds_n) |=> dtack_n);

    p_idle_rdata_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dtack_n |-> (rdata == '0));
endmodule

bind vme_slave_decode vme_slave_decode_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ds_n       (ds_n),
    .dtack_n    (dtack_n),
    .rdata      (rdata),
    .mod_reset  (mod_reset),
    .cnt_we     (cnt_we),
    .thr_we     (thr_we),
    .fifo_pop   (fifo_pop),
    .merged_pop (merged_pop)
);

// File: tb/vme_slave_decode_tb.sv
// Directed bench for vme_slave_decode: one task per scenario.
module vme_slave_decode_tb;
    localparam int NCH = 32;
    localparam int CH_PAGE = 16;
    localparam int DW = 16;
    localparam logic [3:0] MID = 4'h5;
    localparam logic [23:0] BASE = {4'h0, MID, 16'h0000};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [23:0]       addr = '0;
    logic [5:0]        am = '0;
    logic              write_en = 1'b0;
    logic              ds_n = 1'b1;
    logic [DW-1:0]     wdata = '0;
    logic [NCH*DW-1:0] fifo_heads;
    logic [DW-1:0]     merged_data = 16'h5A3C;
    logic [DW-1:0]     blk_cycles = 16'h0123;
    logic              dtack_n;
    logic [DW-1:0]     rdata;
    logic [DW-1:0]     wr_data;
    logic              mod_reset;
    logic              cnt_we;
    logic [NCH-1:0]    thr_we;
    logic [NCH-1:0]    fifo_pop;
    logic              merged_pop;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Results of the last access.
    logic          early;
    logic          g_ack;
    logic          g_rst;
    logic          g_cnt;
    logic [NCH-1:0] g_thr;
    logic [NCH-1:0] g_pop;
    logic          g_mpop;
    logic [DW-1:0] g_rdata;
    logic [DW-1:0] g_wr;
    logic          late_pulse;
    logic          rel_ok;

    always #2 clk = ~clk;

    vme_slave_decode #(.NCH(NCH), .CH_PAGE(CH_PAGE), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .module_id(MID), .addr(addr), .am(am),
        .write_en(write_en), .ds_n(ds_n), .wdata(wdata),
        .fifo_heads(fifo_heads), .merged_data(merged_data), .blk_cycles(blk_cycles),
        .dtack_n(dtack_n), .rdata(rdata), .wr_data(wr_data), .mod_reset(mod_reset),
        .cnt_we(cnt_we), .thr_we(thr_we), .fifo_pop(fifo_pop), .merged_pop(merged_pop)
    );

    function automatic logic [DW-1:0] head_of(int j);
        return 16'hC000 | 16'(j * 16'h0101);
    endfunction

    function automatic logic pulses();
        return mod_reset | cnt_we | (|thr_we) | (|fifo_pop) | merged_pop;
    endfunction

    function automatic logic [23:0] ch_addr(int j, logic [7:0] sub);
        return BASE | {8'h00, 8'(CH_PAGE + j), sub};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One full strobe cycle; records what the outputs did.
    task automatic access(input logic [23:0] a, input logic [5:0] m, input logic w, input logic [15:0] d);
        @(negedge clk);
        addr = a; am = m; write_en = w; wdata = d; ds_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        early = !dtack_n | pulses();
        @(posedge clk);
        @(negedge clk);
        g_ack = !dtack_n; g_rst = mod_reset; g_cnt = cnt_we; g_thr = thr_we;
        g_pop = fifo_pop; g_mpop = merged_pop; g_rdata = rdata; g_wr = wr_data;
        @(negedge clk);
        late_pulse = pulses();
        ds_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rel_ok = dtack_n && (rdata == '0);
    endtask

    task automatic expect_ignored(input string req);
        chk(!g_ack, req, 64'(g_ack), 0);
        chk(!(g_rst | g_cnt | (|g_thr) | (|g_pop) | g_mpop), req,
            64'({g_rst, g_cnt, g_mpop}), 0);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk(dtack_n == 1'b1, "R11 dtack", 64'(dtack_n), 1);
        chk(rdata == '0 && !pulses(), "R11 outputs", 64'(rdata), 0);
    endtask

    task automatic t_reset_write();
        access(BASE | 24'h0000, 6'h3D, 1'b1, 16'h0100);
        chk(g_ack && g_rst, "R2 reset pulse", 64'({g_ack, g_rst}), 3);
        chk(!late_pulse, "R2 single cycle", 64'(late_pulse), 0);
        chk(!early, "R10 not early", 64'(early), 0);
        chk(rel_ok, "R10 release", 64'(rel_ok), 1);
    endtask

    task automatic t_bad_key();
        access(BASE | 24'h0000, 6'h3D, 1'b1, 16'h0101);
        chk(g_ack, "R3 acknowledged", 64'(g_ack), 1);
        chk(!(g_rst | g_cnt | (|g_thr)), "R3 no strobe", 64'({g_rst, g_cnt}), 0);
    endtask

    task automatic t_count_write();
        access(BASE | 24'h0001, 6'h3D, 1'b1, 16'h0258);
        chk(g_ack && g_cnt, "R4 count strobe", 64'({g_ack, g_cnt}), 3);
        chk(g_wr == 16'h0258, "R4 data", 64'(g_wr), 64'h258);
        chk(!late_pulse, "R4 single cycle", 64'(late_pulse), 0);
    endtask

    task automatic t_thr_write(input int j, input logic [15:0] v);
        access(ch_addr(j, 8'h02), 6'h3D, 1'b1, v);
        chk(g_ack && g_thr == (NCH'(1) << j), "R5 threshold select", 64'(g_thr), 64'(NCH'(1) << j));
        chk(g_wr == v, "R5 data", 64'(g_wr), 64'(v));
    endtask

    task automatic t_fifo_read(input int j);
        access(ch_addr(j, 8'h00), 6'h3D, 1'b0, 16'h0);
        chk(g_ack && g_pop == (NCH'(1) << j), "R6 pop select", 64'(g_pop), 64'(NCH'(1) << j));
        chk(g_rdata == head_of(j), "R6 data", 64'(g_rdata), 64'(head_of(j)));
        chk(rel_ok, "R11 rdata cleared", 64'(rel_ok), 1);
    endtask

    task automatic t_merged(input logic [5:0] m);
        access(BASE | 24'h0100, m, 1'b0, 16'h0);
        chk(g_ack && g_mpop, "R7 merged pop", 64'({g_ack, g_mpop}), 3);
        chk(g_rdata == merged_data, "R7 data", 64'(g_rdata), 64'(merged_data));
    endtask

    task automatic t_blkcnt(input logic [5:0] m);
        access(BASE | 24'h0101, m, 1'b0, 16'h0);
        chk(g_ack && g_rdata == blk_cycles, "R8 count read", 64'(g_rdata), 64'(blk_cycles));
        chk(!(g_mpop | (|g_pop)), "R8 no pop", 64'(g_mpop), 0);
    endtask

    task automatic t_ignored();
        access(BASE | 24'h0100, 6'h3D, 1'b0, 16'h0);  expect_ignored("R9 merged with 0x3D");
        access(ch_addr(3, 8'h00), 6'h3B, 1'b0, 16'h0); expect_ignored("R9 fifo with 0x3B");
        access(BASE | 24'h0001, 6'h3D, 1'b0, 16'h0);  expect_ignored("R9 count read dir");
        access(ch_addr(NCH, 8'h02), 6'h3D, 1'b1, 16'h7); expect_ignored("R9 channel past window");
        access(BASE | 24'h0040, 6'h3D, 1'b1, 16'h7);  expect_ignored("R9 unmapped offset");
        access(ch_addr(2, 8'h01), 6'h3D, 1'b1, 16'h7); expect_ignored("R9 unmapped sub-offset");
    endtask

    task automatic t_other_module();
        access({4'h0, 4'h6, 16'h0000}, 6'h3D, 1'b1, 16'h0100); expect_ignored("R1 other index");
        access({4'h1, MID, 16'h0001}, 6'h3D, 1'b1, 16'h0100);  expect_ignored("R1 upper nibble");
    endtask

    task automatic t_abort();
        logic seen;
        seen = 1'b0;
        @(negedge clk);
        addr = BASE | 24'h0001; am = 6'h3D; write_en = 1'b1; wdata = 16'h0999; ds_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        ds_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            seen = seen | !dtack_n | pulses();
        end
        chk(!seen, "R12 abandoned strobe", 64'(seen), 0);
    endtask

    initial begin
        for (int j = 0; j < NCH; j++) fifo_heads[j*DW +: DW] = head_of(j);
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        t_reset_write();
        t_bad_key();
        t_count_write();
        t_thr_write(0, 16'h0011);
        t_thr_write(NCH - 1, 16'h03FF);
        t_thr_write(7, 16'h0042);
        t_fifo_read(0);
        t_fifo_read(NCH - 1);
        t_fifo_read(12);
        t_merged(6'h3B);
        t_merged(6'h3F);
        t_blkcnt(6'h3B);
        t_blkcnt(6'h3F);
        t_ignored();
        t_other_module();
        t_abort();
        t_count_write();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule